// File: doc/BRIEF.md
# Serial Voice-Port Control and Framing Block

This block holds the byte-wide configuration register of a telephony codec's serial port, together with the transmit and receive timeslot logic of that port. The configuration byte selects between a synchronous serial mode and a framed, timeslot-multiplexed mode. It also sets the bit-clock rate, the signalling-channel rate, the companding law and the code assignment. The last two are passed straight to the companding datapath, which lies outside this block.

In framed mode the block runs a 512-cycle frame from the master clock. A frame holds 32 timeslots of 8 bits, and each bit cell is two master-clock cycles long. The block drives a signalling byte into slot 0 and a control byte into slot 1. Each slot has its own output enable, and a disabled slot is released to high impedance. The bytes received in slots 0 and 1 are always captured, whatever the enables say. In serial mode the block produces a bit-clock strobe: every cycle, or once every 32 or 16 master-clock cycles. One shared phase counter drives both modes, and it restarts whenever the clock-select field changes.

Top module: `vport_ctrl`

## Requirements
- R1: After a synchronous reset, cfg_rdata reads 0x02 (serial mode, bit clock equal to master clock, 16 kb/s signalling, µ-law, ITU code), ser_oe is 0, ser_out is 1, c_rdata and d_rdata are 0x00 and the phase counter is 0.
- R2: A byte written with cfg_we reads back unchanged on cfg_rdata from the next cycle. Its fields are: bit7 control-slot enable, bit6 signalling-slot enable, bit5 8 kb/s select, bit4 A-law select, bit3 sign-magnitude select, bits 2:0 clock select (CS).
- R3: bit_tick is 1 on every cycle for CS 000 to 011. For CS 100 it is 1 once every 32 cycles, when the phase counter mod 32 is 0. For CS 101 it is 1 when the counter mod 16 is 0. For CS 111 it is 1 when the counter is even. For CS 110 it never rises.
- R4: A configuration write that changes CS clears the phase counter, so bit_tick (and frame_start in CS 111) is 1 in the following cycle. A write that leaves CS unchanged does not disturb the phase.
- R5: In framed mode (CS 111), frame_start is 1 only when the counter is 0, which gives a 512-cycle frame. Slot n occupies counter values 16n to 16n+15. Bit b of a slot (b=0 is sent first and is the most significant bit) occupies values 16n+2b and 16n+2b+1.
- R6: In framed mode with bit7 set, slot 1 has ser_oe=1 and ser_out equal to bit 7-b of the control transmit byte (c_wdata).
- R7: In framed mode with bit6 set, slot 0 has ser_oe=1. Position b=0 carries bit 7 of the signalling transmit byte. When bit5 is clear, position b=1 carries bit 6 of that byte. Every other position is driven as 1.
- R8: When a slot's enable bit is clear, that slot has ser_oe=0. Slots 2 to 31 always have ser_oe=0. Whenever ser_oe is 0, ser_out is 1.
- R9: In framed mode, ser_in is sampled on the odd counter value of each bit cell in slots 0 and 1. The MSB-first byte appears on d_rdata (slot 0) or c_rdata (slot 1) in the cycle after its last sample, whatever the enable bits are.
- R10: In serial modes (CS other than 111), ser_oe stays 0 and c_rdata and d_rdata hold, whatever the enable bits are.
- R11: law_alaw follows configuration bit4 and code_smag follows bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Current configuration byte |
| c_we | input | 1 | Control transmit byte write strobe |
| c_wdata | input | 8 | Control transmit byte |
| d_we | input | 1 | Signalling transmit byte write strobe |
| d_wdata | input | 8 | Signalling transmit byte |
| c_rdata | output | 8 | Last byte received in slot 1 |
| d_rdata | output | 8 | Last byte received in slot 0 |
| law_alaw | output | 1 | A-law select to the companding datapath |
| code_smag | output | 1 | Sign-magnitude select to the companding datapath |
| bit_tick | output | 1 | Bit-clock strobe, one cycle per bit cell |
| frame_start | output | 1 | First cycle of a frame in framed mode |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Serial transmit drive enable (0 means high impedance) |

## Verification
All port behaviour follows from the phase counter and the configuration byte. A counter that is off by even one cycle shows at once as a bit_tick or frame_start in the wrong cycle, and within 16 cycles as serial data shifted into the wrong bit position. If the counter misses a restart after a CS change, the first strobe after the write lands in the wrong cycle. A wrong receive shift state shows on c_rdata or d_rdata only at the end of slot 0 or slot 1, so it can stay hidden for up to one 512-cycle frame. A stuck enable path shows on ser_oe within the next slot-0 or slot-1 window.

// File: rtl/vport_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial voice port.
// Assumes: configuration is one byte, clock-select in the low three bits.
package vport_pkg;

    typedef enum logic [2:0] {
        CS_DIRECT_512  = 3'b000,
        CS_DIRECT_1536 = 3'b001,
        CS_DIRECT_2048 = 3'b010,
        CS_DIRECT_4096 = 3'b011,
        CS_DIV_SLOW    = 3'b100,
        CS_DIV_FAST    = 3'b101,
        CS_UNUSED      = 3'b110,
        CS_FRAMED      = 3'b111
    } csel_e;

    typedef struct packed {
        logic  c_slot_en;
        logic  d_slot_en;
        logic  d_narrow;
        logic  alaw;
        logic  smag;
        csel_e csel;
    } port_cfg_t;

    localparam logic [7:0] CFG_RESET = 8'h02;

endpackage

// File: rtl/vport_regs.sv
`timescale 1ns/1ps
// Configuration and transmit-byte registers.
// Flags a clock-select change in the cycle of the write so the timebase can restart.
// Assumes: writes are single-cycle strobes; no read side effects.
module vport_regs
    import vport_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              c_we,
    input  logic [BYTE_W-1:0] c_wdata,
    input  logic              d_we,
    input  logic [BYTE_W-1:0] d_wdata,
    output port_cfg_t         cfg_q,
    output logic [BYTE_W-1:0] c_tx_q,
    output logic [BYTE_W-1:0] d_tx_q,
    output logic              csel_chg
);

    // Detect a write that alters the clock-select field.
    always_comb begin
        csel_chg = cfg_we && (cfg_wdata[2:0] != cfg_q.csel);
    end

    // Configuration byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= port_cfg_t'(CFG_RESET);
        end else if (cfg_we) begin
            cfg_q <= port_cfg_t'(cfg_wdata);
        end
    end

    // Transmit byte storage for both timeslots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_tx_q <= '0;
            d_tx_q <= '0;
        end else begin
            if (c_we) c_tx_q <= c_wdata;
            if (d_we) d_tx_q <= d_wdata;
        end
    end

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (BYTE_W'(cfg_q) == $past(cfg_wdata)));

endmodule

// File: rtl/vport_timebase.sv
`timescale 1ns/1ps
// Shared phase counter, bit-clock strobe and frame marker.
// Assumes: frame length and both dividers are powers of two not exceeding the frame.
module vport_timebase
    import vport_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int DIV_SLOW = 32,
    parameter int DIV_FAST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  csel_e            csel,
    input  logic             csel_chg,
    output logic [CNT_W-1:0] cnt_q,
    output logic             bit_tick,
    output logic             frame_start
);

    localparam int SLOW_W = $clog2(DIV_SLOW);
    localparam int FAST_W = $clog2(DIV_FAST);

    // Free-running phase counter, cleared on reset or clock-select change.
    always_ff @(posedge clk) begin
        if (!rst_n || csel_chg) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Bit-clock strobe per clock-select setting.
    always_comb begin
        unique case (csel)
            CS_DIRECT_512, CS_DIRECT_1536,
            CS_DIRECT_2048, CS_DIRECT_4096: bit_tick = 1'b1;
            CS_DIV_SLOW: bit_tick = (cnt_q[SLOW_W-1:0] == '0);
            CS_DIV_FAST: bit_tick = (cnt_q[FAST_W-1:0] == '0);
            CS_FRAMED:   bit_tick = ~cnt_q[0];
            default:     bit_tick = 1'b0;
        endcase
    end

    // Frame marker, framed mode only.
    always_comb begin
        frame_start = (csel == CS_FRAMED) && (cnt_q == '0);
    end

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csel_chg |=> (cnt_q == '0));

    // R3
    slow_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csel == CS_DIV_SLOW && bit_tick && !csel_chg) |=> !bit_tick);

    // R5
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

endmodule

// File: rtl/vport_tx.sv
`timescale 1ns/1ps
// Transmit timeslot multiplexer for framed mode.
// Slot 0 carries one or two signalling bits, slot 1 the control byte; all else released.
// Assumes: bits per slot is a power of two; clk is used only by the checks.
module vport_tx
    import vport_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SLOT_W = 5,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_cfg_t         cfg,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [BYTE_W-1:0] c_tx,
    input  logic [BYTE_W-1:0] d_tx,
    output logic              ser_out,
    output logic              ser_oe
);

    localparam int BIT_W = $clog2(BYTE_W);

    logic              framed;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bpos;
    logic [BIT_W-1:0]  c_idx;

    // Decode slot and bit position from the phase counter.
    always_comb begin
        framed = (cfg.csel == CS_FRAMED);
        slot   = cnt[CNT_W-1 -: SLOT_W];
        bpos   = cnt[BIT_W:1];
        c_idx  = ~bpos;
    end

    // Select drive enable and data for the current bit cell.
    always_comb begin
        ser_oe  = 1'b0;
        ser_out = 1'b1;
        if (framed) begin
            if (slot == SLOT_W'(1) && cfg.c_slot_en) begin
                ser_oe  = 1'b1;
                ser_out = c_tx[c_idx];
            end else if (slot == '0 && cfg.d_slot_en) begin
                ser_oe = 1'b1;
                if (bpos == '0) begin
                    ser_out = d_tx[BYTE_W-1];
                end else if (bpos == BIT_W'(1) && !cfg.d_narrow) begin
                    ser_out = d_tx[BYTE_W-2];
                end
            end
        end
    end

    // R8
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot > SLOT_W'(1)) |-> (!ser_oe && ser_out));

    // R10
    serial_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.csel != CS_FRAMED) |-> !ser_oe);

endmodule

// File: rtl/vport_rx.sv
`timescale 1ns/1ps
// Receive capture for slots 0 and 1 in framed mode, independent of the enables.
// Samples on the second cycle of each bit cell; bytes arrive MSB first.
module vport_rx
    import vport_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SLOT_W = 5,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              framed,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ser_in,
    output logic [BYTE_W-1:0] c_rx_q,
    output logic [BYTE_W-1:0] d_rx_q
);

    localparam int BIT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_nx;
    logic              sample;
    logic              last_bit;
    logic              in_d_slot;

    // Sampling qualifiers and the next shift value.
    always_comb begin
        in_d_slot = (cnt[CNT_W-1 -: SLOT_W] == '0);
        sample    = framed && cnt[0] && (cnt[CNT_W-1 -: SLOT_W] <= SLOT_W'(1));
        last_bit  = (cnt[BIT_W:1] == '1);
        shift_nx  = {shift_q[BYTE_W-2:0], ser_in};
    end

    // Shift register and per-slot byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            c_rx_q  <= '0;
            d_rx_q  <= '0;
        end else if (sample) begin
            shift_q <= shift_nx;
            if (last_bit) begin
                if (in_d_slot) d_rx_q <= shift_nx;
                else           c_rx_q <= shift_nx;
            end
        end
    end

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !framed |=> ($stable(c_rx_q) && $stable(d_rx_q)));

endmodule

// File: rtl/vport_ctrl.sv
`timescale 1ns/1ps
// Serial voice-port control: configuration register, timebase, framed transmit and receive.
// Assumes: a single master clock; the companding datapath consumes law_alaw and code_smag.
module vport_ctrl
    import vport_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int SLOTS    = 32,
    parameter int DIV_SLOW = 32,
    parameter int DIV_FAST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] cfg_rdata,
    input  logic              c_we,
    input  logic [BYTE_W-1:0] c_wdata,
    input  logic              d_we,
    input  logic [BYTE_W-1:0] d_wdata,
    output logic [BYTE_W-1:0] c_rdata,
    output logic [BYTE_W-1:0] d_rdata,
    output logic              law_alaw,
    output logic              code_smag,
    output logic              bit_tick,
    output logic              frame_start,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_oe
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int CNT_W  = SLOT_W + BIT_W + 1;

    port_cfg_t         cfg_q;
    logic [BYTE_W-1:0] c_tx_q;
    logic [BYTE_W-1:0] d_tx_q;
    logic              csel_chg;
    logic [CNT_W-1:0]  cnt_q;

    vport_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .c_we      (c_we),
        .c_wdata   (c_wdata),
        .d_we      (d_we),
        .d_wdata   (d_wdata),
        .cfg_q     (cfg_q),
        .c_tx_q    (c_tx_q),
        .d_tx_q    (d_tx_q),
        .csel_chg  (csel_chg)
    );

    vport_timebase #(.CNT_W(CNT_W), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_time (
        .clk         (clk),
        .rst_n       (rst_n),
        .csel        (cfg_q.csel),
        .csel_chg    (csel_chg),
        .cnt_q       (cnt_q),
        .bit_tick    (bit_tick),
        .frame_start (frame_start)
    );

    vport_tx #(.BYTE_W(BYTE_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg_q),
        .cnt     (cnt_q),
        .c_tx    (c_tx_q),
        .d_tx    (d_tx_q),
        .ser_out (ser_out),
        .ser_oe  (ser_oe)
    );

    vport_rx #(.BYTE_W(BYTE_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .framed (cfg_q.csel == CS_FRAMED),
        .cnt    (cnt_q),
        .ser_in (ser_in),
        .c_rx_q (c_rdata),
        .d_rx_q (d_rdata)
    );

    // Expose configuration fields to the port and the companding path.
    always_comb begin
        cfg_rdata = BYTE_W'(cfg_q);
        law_alaw  = cfg_q.alaw;
        code_smag = cfg_q.smag;
    end

endmodule

// File: tb/vport_ctrl_tb.sv
`timescale 1ns/1ps
module vport_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       c_we = 1'b0;
    logic [7:0] c_wdata = 8'h00;
    logic       d_we = 1'b0;
    logic [7:0] d_wdata = 8'h00;
    logic       ser_in = 1'b0;
    logic [7:0] cfg_rdata, c_rdata, d_rdata;
    logic       law_alaw, code_smag, bit_tick, frame_start, ser_out, ser_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 0;
    bit done = 0;

    // behavioural reference state
    int m_cfg, m_c, m_d, m_cnt, m_crx, m_drx, m_sh;

    always #2 clk = ~clk;

    vport_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .c_we(c_we), .c_wdata(c_wdata), .d_we(d_we),
        .d_wdata(d_wdata), .c_rdata(c_rdata), .d_rdata(d_rdata),
        .law_alaw(law_alaw), .code_smag(code_smag), .bit_tick(bit_tick),
        .frame_start(frame_start), .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model step and comparison on every clock.
    always @(posedge clk) begin
        int csl, slot, b;
        if (!rst_n) begin
            m_cfg = 2; m_c = 0; m_d = 0; m_cnt = 0; m_crx = 0; m_drx = 0; m_sh = 0;
        end else begin
            csl  = m_cfg % 8;
            slot = m_cnt / 16;
            b    = (m_cnt / 2) % 8;
            if (csl == 7 && (m_cnt % 2) == 1 && slot < 2) begin
                m_sh = ((m_sh * 2) + int'(ser_in)) % 256;
                if (b == 7) begin
                    if (slot == 0) m_drx = m_sh;
                    else           m_crx = m_sh;
                end
            end
            if (cfg_we && (int'(cfg_wdata) % 8) != csl) m_cnt = 0;
            else m_cnt = (m_cnt + 1) % 512;
            if (cfg_we) m_cfg = int'(cfg_wdata);
            if (c_we) m_c = int'(c_wdata);
            if (d_we) m_d = int'(d_wdata);
        end
        #1;
        if (cmp_on) compare();
    end

    task automatic compare();
        int csl = m_cfg % 8;
        int slot = m_cnt / 16;
        int b = (m_cnt / 2) % 8;
        int e_tick, e_oe, e_out;
        string t;
        case (csl)
            0, 1, 2, 3: e_tick = 1;
            4: e_tick = (m_cnt % 32 == 0) ? 1 : 0;
            5: e_tick = (m_cnt % 16 == 0) ? 1 : 0;
            7: e_tick = (m_cnt % 2 == 0) ? 1 : 0;
            default: e_tick = 0;
        endcase
        e_oe = 0; e_out = 1; t = "R8";
        if (csl != 7) t = "R10";
        else if (slot == 1 && (m_cfg / 128) % 2 == 1) begin
            t = "R6"; e_oe = 1; e_out = (m_c >> (7 - b)) % 2;
        end else if (slot == 0 && (m_cfg / 64) % 2 == 1) begin
            t = "R7"; e_oe = 1;
            if (b == 0) e_out = (m_d >> 7) % 2;
            else if (b == 1 && (m_cfg / 32) % 2 == 0) e_out = (m_d >> 6) % 2;
        end
        chk("R2", "cfg_rdata", int'(cfg_rdata), m_cfg);
        chk("R11", "law_alaw", int'(law_alaw), (m_cfg / 16) % 2);
        chk("R11", "code_smag", int'(code_smag), (m_cfg / 8) % 2);
        chk("R3", "bit_tick", int'(bit_tick), e_tick);
        chk("R5", "frame_start", int'(frame_start), (csl == 7 && m_cnt == 0) ? 1 : 0);
        chk(t, "ser_oe", int'(ser_oe), e_oe);
        chk(t, "ser_out", int'(ser_out), e_out);
        chk("R9", "c_rdata", int'(c_rdata), m_crx);
        chk("R9", "d_rdata", int'(d_rdata), m_drx);
    endtask

    task automatic wr_cfg(logic [7:0] v, bit restart);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
        // R4: a clock-select change makes the strobe fire in the next cycle
        if (restart) chk("R4", "bit_tick after restart", int'(bit_tick), 1);
    endtask

    task automatic wr_c(logic [7:0] v);
        @(negedge clk); c_we = 1'b1; c_wdata = v;
        @(negedge clk); c_we = 1'b0;
    endtask

    task automatic wr_d(logic [7:0] v);
        @(negedge clk); d_we = 1'b1; d_wdata = v;
        @(negedge clk); d_we = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    // Serial input pattern from a bench-side shift register.
    initial begin
        logic [15:0] lf = 16'hACE1;
        forever begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ser_in = lf[0];
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "cfg_rdata", int'(cfg_rdata), 2);
        chk("R1", "ser_oe", int'(ser_oe), 0);
        chk("R1", "ser_out", int'(ser_out), 1);
        chk("R1", "c_rdata", int'(c_rdata), 0);
        chk("R1", "d_rdata", int'(d_rdata), 0);
        rst_n = 1'b1;
        cmp_on = 1;
        run(40);
        wr_c(8'hA5);
        wr_d(8'h80);
        wr_cfg(8'hC7, 1);
        chk("R5", "frame_start after restart", int'(frame_start), 1);
        run(1100);
        wr_d(8'h40);
        wr_cfg(8'hA7, 0);
        run(600);
        wr_cfg(8'h47, 0);
        wr_d(8'hC0);
        run(600);
        wr_cfg(8'h07, 0);
        run(600);
        wr_cfg(8'hD4, 1);
        run(150);
        wr_cfg(8'h14, 0);
        run(100);
        wr_cfg(8'hC5, 1);
        run(120);
        wr_cfg(8'h00, 0);
        run(30);
        wr_cfg(8'h09, 0);
        run(30);
        wr_cfg(8'h1B, 0);
        run(30);
        wr_cfg(8'h06, 0);
        run(60);
        wr_cfg(8'h87, 1);
        wr_c(8'h3C);
        run(700);
        wr_cfg(8'hE7, 0);
        run(600);
        done = 1;
        cmp_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule